// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block drives the two-wire station management bus that a MAC uses to reach the registers of Ethernet PHYs. It follows the IEEE 802.3 Clause 22 frame format. Software sees one 32-bit command and status word. Writing that word while the block is idle starts a serial frame at once; no separate start bit exists. The same word, read back, shows the busy flag, the read-valid flag, the command fields and the 16-bit data.

The management clock comes from the system clock through a free-running divider. Each level of the management clock lasts `HALF_DIV` system cycles. The master changes its data pin and output enable only in the cycle in which the management clock falls, and it samples the PHY on the rising edge. During a read the master releases the line at turnaround. The read counts as valid only when the PHY pulls the second turnaround bit low.

Top module: `mdio_c22_master`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `reg_rdata` is zero, `mdc` is low and `mdio_oe` is low.
- R2: `mdc` starts low after reset and toggles every `HALF_DIV` system clock cycles without stopping, so its period is 2*`HALF_DIV` cycles.
- R3: A `reg_wr` pulse accepted while bit 28 (busy) is clear sets bit 28 in the next cycle. In the same cycle, bits 26:0 show the new command: bit 26 is the operation (1 for read, 0 for write), bits 25:21 the register number, bits 20:16 the PHY address and bits 15:0 the write data. Bits 31:29 always read zero.
- R4: A write command sends 64 driven bits, MSB first, each held from one falling edge of `mdc` to the next: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits.
- R5: A read command drives only the first 46 bits (32 ones, 01, opcode 10, PHY address, register number). `mdio_oe` is low during the two turnaround bits and the 16 data bits, and it is low whenever busy is clear.
- R6: `mdio_o` and `mdio_oe` change only in the system cycle in which `mdc` goes from high to low.
- R7: When a read completes, bits 15:0 hold the 16 bits sampled from `mdio_i` on the rising `mdc` edges of the data field, MSB first. They appear in the same cycle in which busy clears.
- R8: Bit 27 (read-valid) is set when a read completes only if `mdio_i` was low at the rising edge of the second turnaround bit. It is cleared when a command is accepted, it stays clear after a write, and it is never set while busy.
- R9: A `reg_wr` that arrives while busy is set is ignored. Bits 26:0 and the frame in flight are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | One-cycle write strobe for the command word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Status, command fields and data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable of the serial data pin |
| mdio_i | input | 1 | Serial data seen on the pin |

## Verification
Busy and the new command fields are due at the first clock edge after the cycle in which the write strobe is high. The bench samples them at the following falling system clock edge, and in that same sample it checks that a write issued while busy leaves the word unchanged. The level of `mdc` is predicted from the number of edges since reset and compared on every cycle, and any change on the data pins is checked against a falling `mdc` edge in that same cycle. Serial bits are collected at each rising `mdc` edge. The PHY model presents its next bit right after that edge, a full management clock period before the master samples it. The read result and read-valid are checked in the first sample in which busy reads clear, because the design retires them on the same edge.

// File: rtl/mdio_c22_pkg.sv
package mdio_c22_pkg;
  localparam int PREAMBLE_LEN = 32;
  localparam int ADDR_W       = 5;
  localparam int DATA_W       = 16;
  localparam int FRAME_LEN    = PREAMBLE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_POS       = FRAME_LEN - DATA_W - 2;
  localparam int BIT_OP       = 26;
  localparam int BIT_VALID    = 27;
  localparam int BIT_BUSY     = 28;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] regad;
    logic [ADDR_W-1:0] phy;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mdio_c22_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mgmt_cmd_t         cmd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              last,
  output logic              ta_ok,
  output logic [DATA_W-1:0] rx_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] REL_CNT  = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] TA2_CNT  = CNT_W'(TA_POS + 2);

  logic [FRAME_LEN-1:0] shreg;
  logic [CNT_W-1:0]     bitcnt;
  logic                 is_rd;

  assign last = busy && fall_tick && (bitcnt == END_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      ta_ok   <= 1'b0;
      rx_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        bitcnt <= '0;
        is_rd  <= cmd.rd;
        ta_ok  <= 1'b0;
        shreg  <= {{PREAMBLE_LEN{1'b1}}, 2'b01, (cmd.rd ? 2'b10 : 2'b01),
                   cmd.phy, cmd.regad, 2'b10,
                   (cmd.rd ? {DATA_W{1'b0}} : cmd.data)};
      end
    end else begin
      if (fall_tick) begin
        if (bitcnt == END_CNT) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          mdio_o  <= shreg[FRAME_LEN-1];
          shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
          mdio_oe <= !is_rd || (bitcnt < REL_CNT);
          bitcnt  <= bitcnt + CNT_W'(1);
        end
      end
      if (rise_tick && is_rd && bitcnt != '0) begin
        if (bitcnt == TA2_CNT) ta_ok <= !mdio_i;
        if (bitcnt > TA2_CNT)  rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
  import mdio_c22_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mgmt_cmd_t         cmd_q;
  mgmt_cmd_t         cmd_new;
  logic              valid_q;
  logic              busy;
  logic              frame_last;
  logic              start;
  logic              ta_ok;
  logic [DATA_W-1:0] rx_data;
  logic              rise_tick;
  logic              fall_tick;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[31:BIT_OP+1];
  assign cmd_new   = mgmt_cmd_t'(reg_wdata[BIT_OP:0]);
  assign start     = reg_wr && !busy;

  mdc_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mgmt_frame_engine u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (cmd_new),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .last      (frame_last),
    .ta_ok     (ta_ok),
    .rx_data   (rx_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      valid_q <= 1'b0;
    end else if (start) begin
      cmd_q   <= cmd_new;
      valid_q <= 1'b0;
    end else if (frame_last && cmd_q.rd) begin
      cmd_q.data <= rx_data;
      valid_q    <= ta_ok;
    end
  end

  assign reg_rdata = {3'b000, busy, valid_q, cmd_q};
endmodule

// File: rtl/mdio_c22_checker.sv
module mdio_c22_checker (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        frame_last
);
  assert_launch_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_rdata[28]) |=> reg_rdata[28]);

  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_rdata[28] && !frame_last) |=> $stable(reg_rdata[26:0]));

  assert_pins_move_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc));

  assert_released_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[28] |-> !mdio_oe);

  assert_no_valid_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[28] |-> !reg_rdata[27]);

  assert_high_bits_zero_R3: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[31:29] == 3'b000);
endmodule

bind mdio_c22_master mdio_c22_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_rdata  (reg_rdata),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .frame_last (frame_last)
);

// File: tb/mdio_c22_master_bench.sv
module mdio_c22_master_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mdio_i = 1'b1;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mdio_c22_master #(.HALF_DIV(HALF)) u_mdio_c22_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  int          edges;
  logic        ta_drive = 1'b0;
  logic [15:0] phy_data = '0;
  logic        prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0, prev_busy = 1'b0;
  bit          started = 0;
  int          ridx = 0;
  int          driven = 0;
  logic [63:0] obs = '0;

  function automatic logic phy_bit(input int k);
    if (k == 47) return ta_drive;
    if (k >= 48 && k < 64) return phy_data[63-k];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(mdc === 1'((edges / HALF) % 2), "R2", "mdc level", mdc, (edges / HALF) % 2);
      if (mdio_o !== prev_o || mdio_oe !== prev_oe)
        chk(prev_mdc && !mdc, "R6", "pin change without mdc fall", {prev_mdc, mdc}, 2'b10);
      if (reg_rdata[28] && !prev_busy) begin
        started = 0; ridx = 0; driven = 0; obs = '0; mdio_i = 1'b1;
      end
      if (!prev_mdc && mdc && reg_rdata[28]) begin
        if (mdio_oe) started = 1;
        if (started && ridx < 64) begin
          if (mdio_oe) begin
            obs[63-ridx] = mdio_o;
            driven++;
          end
          ridx++;
          mdio_i = phy_bit(ridx);
        end
      end
    end
    prev_mdc  = mdc;
    prev_o    = mdio_o;
    prev_oe   = mdio_oe;
    prev_busy = reg_rdata[28];
  end

  task automatic wait_idle(input string req);
    int n = 0;
    while (reg_rdata[28] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(!reg_rdata[28], req, "busy never cleared", reg_rdata[28], 0);
  endtask

  task automatic launch(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] data, input bit ta, input logic [15:0] pdata);
    ta_drive = ta;
    phy_data = pdata;
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = {5'b0, rd, rg, phy, data};
    @(negedge clk);
    reg_wr = 1'b0;
    chk(reg_rdata[28] === 1'b1, "R3", "busy after launch", reg_rdata[28], 1);
    chk(reg_rdata[26:0] === {rd, rg, phy, data}, "R3", "fields", reg_rdata[26:0], {rd, rg, phy, data});
    chk(reg_rdata[27] === 1'b0, "R8", "valid cleared on launch", reg_rdata[27], 0);
  endtask

  task automatic finish_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] data, input bit ta, input logic [15:0] pdata);
    logic [63:0] exp;
    wait_idle(rd ? "R7" : "R4");
    exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, data};
    if (rd) begin
      chk(driven == 46, "R5", "driven bit count", driven, 46);
      chk(obs[63:18] === exp[63:18], "R5", "read header bits", obs[63:18], exp[63:18]);
      chk(reg_rdata[15:0] === pdata, "R7", "captured data", reg_rdata[15:0], pdata);
      chk(reg_rdata[27] === !ta, "R8", "read-valid", reg_rdata[27], !ta);
      chk(reg_rdata[31:16] === {3'b0, 1'b0, !ta, 1'b1, rg, phy}, "R3", "upper word after read",
          reg_rdata[31:16], {3'b0, 1'b0, !ta, 1'b1, rg, phy});
    end else begin
      chk(driven == 64, "R4", "driven bit count", driven, 64);
      chk(obs === exp, "R4", "write frame", obs, exp);
      chk(reg_rdata === {3'b0, 1'b0, 1'b0, 1'b0, rg, phy, data}, "R8", "word after write",
          reg_rdata, {3'b0, 1'b0, 1'b0, 1'b0, rg, phy, data});
    end
    chk(mdio_oe === 1'b0, "R5", "released when idle", mdio_oe, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_rdata === 32'h0, "R1", "rdata in reset", reg_rdata, 0);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "mdc/oe in reset", {mdc, mdio_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(reg_rdata === 32'h0 && mdio_oe === 1'b0, "R1", "state after reset", reg_rdata, 0);

    launch(1'b0, 5'h01, 5'h00, 16'hA5C3, 1'b0, 16'h0);
    finish_cmd(1'b0, 5'h01, 5'h00, 16'hA5C3, 1'b0, 16'h0);

    launch(1'b1, 5'h1F, 5'h1F, 16'h0, 1'b0, 16'h1234);
    finish_cmd(1'b1, 5'h1F, 5'h1F, 16'h0, 1'b0, 16'h1234);

    // write right after a valid read clears the flag (R8)
    launch(1'b0, 5'h0A, 5'h15, 16'h00FF, 1'b0, 16'h0);
    finish_cmd(1'b0, 5'h0A, 5'h15, 16'h00FF, 1'b0, 16'h0);

    // PHY does not answer: second turnaround bit stays high (R8)
    launch(1'b1, 5'h03, 5'h02, 16'h0, 1'b1, 16'hFFFF);
    finish_cmd(1'b1, 5'h03, 5'h02, 16'h0, 1'b1, 16'hFFFF);

    // command while busy is ignored (R9)
    launch(1'b0, 5'h12, 5'h09, 16'h5A5A, 1'b0, 16'h0);
    repeat (20) @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = {5'b0, 1'b1, 5'h1C, 5'h07, 16'hDEAD};
    @(negedge clk);
    reg_wr = 1'b0;
    chk(reg_rdata[28:0] === {1'b1, 1'b0, 1'b0, 5'h09, 5'h12, 16'h5A5A}, "R9", "word after ignored write",
        reg_rdata[28:0], {1'b1, 1'b0, 1'b0, 5'h09, 5'h12, 16'h5A5A});
    finish_cmd(1'b0, 5'h12, 5'h09, 16'h5A5A, 1'b0, 16'h0);

    launch(1'b1, 5'h00, 5'h02, 16'h0, 1'b0, 16'h8001);
    finish_cmd(1'b1, 5'h00, 5'h02, 16'h0, 1'b0, 16'h8001);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule